// File: doc/BRIEF.md
# CAN Data Frame Transmitter with Bitwise Arbitration

This block turns one queued CAN data frame into a serial bit stream on a wired-AND bus. Logic 0 is the dominant level and logic 1 is the recessive level. The frame advances by one bit on each pulse of a bit-time enable that a separate timing block supplies. The stream carries the bits in frame order and has no stuff bits. A companion block inserts the stuff bits into the stream and computes the 15-bit CRC, which is handed in with the request.

On each enable, the block reads the bus level back and compares it with the bit it is driving.
- **Identifier or RTR bit:** if the block drives recessive and reads dominant, another node is sending a higher-priority frame. The block stops driving at once and then waits for the bus to go quiet before it reports the loss, so the request can be retried.
- **Any other bit except the ACK slot:** a mismatch aborts the frame with a bit-error flag.
- **ACK slot:** the block drives recessive there, and a dominant readback records that a receiver acknowledged the frame.

Top module: `can_frame_tx`

## Requirements
- R1: Out of reset and whenever `busy` is low, `tx_bit` is 1 (recessive) and `done` is low. A request seen while idle raises `busy` on the next clock, and the first bit driven is the dominant start-of-frame bit.
- R2: The frame is a fixed sequence of bit positions, and position p+1 replaces position p only at a clock edge where `bit_tick` is high; `tx_bit` holds its value between enables. The sequence is:
  - position 0: start of frame (0);
  - positions 1 to 11: identifier, most significant bit first;
  - position 12: RTR, driven 0;
  - positions 13 to 14: two reserved bits, driven 0;
  - positions 15 to 18: data length code, most significant bit first;
  - then the data bytes: byte k is taken from `tx_data[8k+7:8k]`, byte 0 is sent first, and each byte is sent most significant bit first;
  - then the 15 CRC bits from `tx_crc`, most significant bit first;
  - then one CRC delimiter (1), the ACK slot (1), one ACK delimiter (1) and seven end-of-frame bits (1).
- R3: The number of data bytes is the data length code, limited to 8. The code field itself carries the requested 4-bit value unchanged. A frame therefore lasts 44 + 8·bytes bit times.
- R4: At positions 1 to 12, if `tx_bit` is 1 when `bit_tick` samples `bus_rx` as 0:
  - `arb_lost` rises on that edge;
  - `tx_bit` stays 1 for the rest of the attempt;
  - `busy` stays high.
- R5: After a loss, the block counts consecutive recessive `bus_rx` samples taken on `bit_tick`; a dominant sample resets the count to zero. When the count reaches `IDLE_RUN` (default 11), `done` pulses for one cycle with `arb_lost` high and `busy` low.
- R6: At any position outside the ACK slot, a readback that differs from the driven bit (and is not an arbitration loss under R4) ends the frame on that edge: `done` pulses with `bit_err` high and `busy` low.
- R7: At the ACK slot, a dominant readback sets `ack_seen`. Sampling the last end-of-frame bit pulses `done` with `ack_seen` showing whether the acknowledge arrived and with `arb_lost` and `bit_err` low. All three flags hold their values until the next request is accepted.
- R8: A request presented while `busy` is high is ignored. The identifier, length, data and CRC latched at acceptance keep driving the frame even if the request inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking the bit-time sample point |
| tx_req | input | 1 | Request to send a frame, taken when idle |
| tx_id | input | 11 | Identifier; a lower value has higher priority |
| tx_dlc | input | 4 | Data length code |
| tx_data | input | 64 | Payload; byte k in bits 8k+7 down to 8k |
| tx_crc | input | 15 | CRC sequence supplied by the companion block |
| bus_rx | input | 1 | Bus level read back (wired-AND of all drivers) |
| tx_bit | output | 1 | Bit driven toward the bus; 1 releases it |
| busy | output | 1 | High from acceptance until the attempt ends |
| done | output | 1 | One-cycle pulse at the end of every attempt |
| ack_seen | output | 1 | The ACK slot was read back dominant |
| arb_lost | output | 1 | The attempt lost arbitration |
| bit_err | output | 1 | The attempt was aborted by a readback mismatch |

## Verification
The bench aims at the arbitration boundary. It forces losses at an interior identifier bit and at the last identifier bit. It also puts dominant bits into the wait that follows a loss. A design that checked one position too few would keep driving dominant bits into the winner's frame. A design that kept counting quiet bits across a dominant one would release too early.

A length code above eight is checked for both payload truncation and the unchanged code field. A wrong limit would shift the CRC and the end of the frame by whole bytes.

A forced mismatch inside the payload must abort the frame rather than report a loss.

Request inputs are changed on purpose while a frame is running. A design that re-latched them would change bits in the middle of the frame.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int ID_W      = 11;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int CRC_W     = 15;
  localparam int RSV_W     = 2;
  localparam int EOF_LEN   = 7;
  localparam int DATA_W    = 8 * MAX_BYTES;
  // start bit + identifier + RTR + reserved + length code
  localparam int HDR_LEN   = 1 + ID_W + 1 + RSV_W + DLC_W;
  // CRC + CRC delimiter + ACK slot + ACK delimiter + end of frame
  localparam int TAIL_LEN  = CRC_W + 3 + EOF_LEN;
  localparam int MAX_LEN   = HDR_LEN + DATA_W + TAIL_LEN;
  localparam int POS_W     = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_YIELD} tx_state_e;

  function automatic int payload_bytes(input logic [DLC_W-1:0] dlc);
    return (int'(dlc) > MAX_BYTES) ? MAX_BYTES : int'(dlc);
  endfunction

  function automatic int frame_len(input logic [DLC_W-1:0] dlc);
    return HDR_LEN + 8 * payload_bytes(dlc) + TAIL_LEN;
  endfunction

  // Bit at a frame position, before stuffing.
  function automatic logic frame_bit(input int pos,
                                     input logic [ID_W-1:0]   id,
                                     input logic [DLC_W-1:0]  dlc,
                                     input logic [DATA_W-1:0] data,
                                     input logic [CRC_W-1:0]  crc);
    logic [ID_W-1:0]   t_id;
    logic [DLC_W-1:0]  t_dlc;
    logic [DATA_W-1:0] t_data;
    logic [CRC_W-1:0]  t_crc;
    int nb;
    int d;
    int c;
    nb = 8 * payload_bytes(dlc);
    if (pos == 0) return 1'b0;
    if (pos <= ID_W) begin
      t_id = id >> (ID_W - pos);
      return t_id[0];
    end
    if (pos < 1 + ID_W + 1 + RSV_W) return 1'b0;
    if (pos < HDR_LEN) begin
      t_dlc = dlc >> (HDR_LEN - 1 - pos);
      return t_dlc[0];
    end
    d = pos - HDR_LEN;
    if (d < nb) begin
      t_data = data >> (8 * (d / 8) + 7 - (d % 8));
      return t_data[0];
    end
    c = d - nb;
    if (c < CRC_W) begin
      t_crc = crc >> (CRC_W - 1 - c);
      return t_crc[0];
    end
    return 1'b1;
  endfunction
endpackage

// File: rtl/can_tx_seq.sv
module can_tx_seq
  import can_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ID_W-1:0]   id_in,
  input  logic [DLC_W-1:0]  dlc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              cur_bit,
  output logic              last_bit,
  output logic              in_arb,
  output logic              ack_slot
);
  logic [ID_W-1:0]   id_q;
  logic [DLC_W-1:0]  dlc_q;
  logic [DATA_W-1:0] data_q;
  logic [CRC_W-1:0]  crc_q;
  logic [POS_W-1:0]  pos_q;
  int                len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q   <= '0;
      dlc_q  <= '0;
      data_q <= '0;
      crc_q  <= '0;
      pos_q  <= '0;
    end else if (load) begin
      id_q   <= id_in;
      dlc_q  <= dlc_in;
      data_q <= data_in;
      crc_q  <= crc_in;
      pos_q  <= '0;
    end else if (advance) begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  always_comb begin
    len      = frame_len(dlc_q);
    cur_bit  = frame_bit(int'(pos_q), id_q, dlc_q, data_q, crc_q);
    last_bit = (int'(pos_q) == len - 1);
    in_arb   = (int'(pos_q) >= 1) && (int'(pos_q) <= ID_W + 1);
    ack_slot = (int'(pos_q) == len - 2 - EOF_LEN);
  end

  // Position moves by exactly one per enabled bit (R2)
  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (int'(pos_q) == int'($past(pos_q)) + 1));
endmodule

// File: rtl/can_tx_mon.sv
module can_tx_mon #(
  parameter int IDLE_RUN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic driven,
  input  logic bus_rx,
  input  logic in_arb,
  input  logic ack_slot,
  input  logic yield_en,
  input  logic step,
  output logic ev_arb_loss,
  output logic ev_bit_err,
  output logic ev_bus_idle
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  logic [RUN_W-1:0] run_q;

  assign ev_arb_loss = sample && in_arb && driven && !bus_rx;
  assign ev_bit_err  = sample && !ack_slot && (driven != bus_rx) && !ev_arb_loss;
  assign ev_bus_idle = yield_en && step && bus_rx && (run_q == RUN_W'(IDLE_RUN - 1));

  // Length of the current recessive run seen while yielding
  always_ff @(posedge clk) begin
    if (!rst_n || !yield_en) begin
      run_q <= '0;
    end else if (step) begin
      run_q <= bus_rx ? run_q + 1'b1 : '0;
    end
  end

  // A dominant sample while yielding always restarts the quiet count (R5)
  p_run_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (yield_en && step && !bus_rx) |=> (run_q == '0));
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int IDLE_RUN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_req,
  input  logic [ID_W-1:0]   tx_id,
  input  logic [DLC_W-1:0]  tx_dlc,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [CRC_W-1:0]  tx_crc,
  input  logic              bus_rx,
  output logic              tx_bit,
  output logic              busy,
  output logic              done,
  output logic              ack_seen,
  output logic              arb_lost,
  output logic              bit_err
);
  tx_state_e state_q;
  logic accept, sample;
  logic cur_bit, last_bit, in_arb, ack_slot;
  logic ev_arb_loss, ev_bit_err, ev_bus_idle;

  assign accept = tx_req && (state_q == ST_IDLE);
  assign sample = bit_tick && (state_q == ST_SEND);

  can_tx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .load(accept), .advance(sample),
    .id_in(tx_id), .dlc_in(tx_dlc), .data_in(tx_data), .crc_in(tx_crc),
    .cur_bit(cur_bit), .last_bit(last_bit), .in_arb(in_arb), .ack_slot(ack_slot)
  );

  can_tx_mon #(.IDLE_RUN(IDLE_RUN)) u_mon (
    .clk(clk), .rst_n(rst_n), .sample(sample), .driven(cur_bit), .bus_rx(bus_rx),
    .in_arb(in_arb), .ack_slot(ack_slot), .yield_en(state_q == ST_YIELD),
    .step(bit_tick), .ev_arb_loss(ev_arb_loss), .ev_bit_err(ev_bit_err),
    .ev_bus_idle(ev_bus_idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done     <= 1'b0;
      ack_seen <= 1'b0;
      arb_lost <= 1'b0;
      bit_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_SEND;
          ack_seen <= 1'b0;
          arb_lost <= 1'b0;
          bit_err  <= 1'b0;
        end
        ST_SEND: if (sample) begin
          if (ev_arb_loss) begin
            state_q  <= ST_YIELD;
            arb_lost <= 1'b1;
          end else if (ev_bit_err) begin
            state_q <= ST_IDLE;
            bit_err <= 1'b1;
            done    <= 1'b1;
          end else begin
            if (ack_slot) ack_seen <= !bus_rx;
            if (last_bit) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end
          end
        end
        ST_YIELD: if (ev_bus_idle) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign tx_bit = (state_q == ST_SEND) ? cur_bit : 1'b1;

  p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_bit);
  p_sof_dominant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_bit);
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable(tx_bit));
  p_release_on_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_loss |=> (tx_bit && arb_lost && busy));
  p_yield_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_YIELD) |-> tx_bit);
  p_abort_on_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit_err |=> (done && bit_err && !busy));
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/test_can_frame_tx.sv
module test_can_frame_tx;
  import can_tx_pkg::*;
  localparam int IDLE_RUN = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic tx_req = 1'b0;
  logic peer_bit = 1'b1;
  logic [ID_W-1:0]   tx_id = '0;
  logic [DLC_W-1:0]  tx_dlc = '0;
  logic [DATA_W-1:0] tx_data = '0;
  logic [CRC_W-1:0]  tx_crc = '0;
  logic bus_rx, tx_bit, busy, done, ack_seen, arb_lost, bit_err;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit peer_q[$];
  bit noise = 1'b0;

  assign bus_rx = tx_bit & peer_bit;

  can_frame_tx #(.IDLE_RUN(IDLE_RUN)) i_can_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_req(tx_req),
    .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_crc(tx_crc),
    .bus_rx(bus_rx), .tx_bit(tx_bit), .busy(busy), .done(done),
    .ack_seen(ack_seen), .arb_lost(arb_lost), .bit_err(bit_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  function automatic bit bit_at(input logic [63:0] v, input int k);
    logic [63:0] t;
    t = v >> k;
    return t[0];
  endfunction

  function automatic int ack_index(input logic [3:0] dlc);
    int nb;
    nb = (int'(dlc) > 8) ? 8 : int'(dlc);
    return 44 + 8 * nb - 9;
  endfunction

  // Peer stays recessive until position idx, where it drives dominant
  task automatic peer_dom_at(input int idx);
    peer_q.delete();
    for (int i = 0; i < idx; i++) peer_q.push_back(1'b1);
    peer_q.push_back(1'b0);
  endtask

  task automatic run_frame(input string tag, input logic [10:0] id, input logic [3:0] dlc,
                           input logic [63:0] data, input logic [14:0] crc, input int gap);
    bit exp_q[$];
    int nb, len, ackpos, run;
    bit lost, exp_ack, drive, pb, bus, fin;
    nb = (int'(dlc) > 8) ? 8 : int'(dlc);
    exp_q.push_back(1'b0);
    for (int k = 10; k >= 0; k--) exp_q.push_back(bit_at(64'(id), k));
    repeat (3) exp_q.push_back(1'b0);
    for (int k = 3; k >= 0; k--) exp_q.push_back(bit_at(64'(dlc), k));
    for (int b = 0; b < nb; b++)
      for (int k = 7; k >= 0; k--) exp_q.push_back(bit_at(data, 8 * b + k));
    for (int k = 14; k >= 0; k--) exp_q.push_back(bit_at(64'(crc), k));
    repeat (10) exp_q.push_back(1'b1);
    len = exp_q.size();
    ackpos = len - 9;

    @(negedge clk);
    tx_req = 1'b1; tx_id = id; tx_dlc = dlc; tx_data = data; tx_crc = crc;
    @(negedge clk);
    tx_req = 1'b0;
    chk({tag, " R1 busy after request"}, busy, 1'b1);
    chk({tag, " R1 start bit dominant"}, tx_bit, 1'b0);

    lost = 0; run = 0; exp_ack = 0; fin = 0;
    for (int i = 0; i < 400; i++) begin
      drive = (lost || i >= len) ? 1'b1 : exp_q[i];
      pb = (i < peer_q.size()) ? peer_q[i] : 1'b1;
      peer_bit = pb;
      for (int g = 0; g < gap; g++) begin
        if (noise && i < 20) begin
          tx_req = 1'b1; tx_id = ~id; tx_dlc = ~dlc; tx_data = ~data; tx_crc = ~crc;
        end
        @(negedge clk);
        chk($sformatf("%s R2 R8 bit %0d value", tag, i), tx_bit, drive);
        chk($sformatf("%s R2 bit %0d busy", tag, i), busy, 1'b1);
      end
      tx_req = 1'b0;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      bus = drive & pb;
      if (!lost) begin
        if (i >= 1 && i <= 12 && drive && !bus) begin
          lost = 1; run = 0;
          chk({tag, " R4 arb_lost raised"}, arb_lost, 1'b1);
          chk({tag, " R4 bus released"}, tx_bit, 1'b1);
          chk({tag, " R4 still busy"}, busy, 1'b1);
          continue;
        end
        if (i != ackpos && bus != drive) begin
          chk({tag, " R6 done on mismatch"}, done, 1'b1);
          chk({tag, " R6 bit_err"}, bit_err, 1'b1);
          chk({tag, " R6 not busy"}, busy, 1'b0);
          fin = 1;
          break;
        end
        if (i == ackpos) exp_ack = !bus;
        if (i == len - 1) begin
          chk({tag, " R7 done at end"}, done, 1'b1);
          chk({tag, " R7 ack_seen"}, ack_seen, exp_ack);
          chk({tag, " R7 no arb_lost"}, arb_lost, 1'b0);
          chk({tag, " R7 no bit_err"}, bit_err, 1'b0);
          chk({tag, " R3 R7 not busy"}, busy, 1'b0);
          fin = 1;
          break;
        end
        chk($sformatf("%s R3 no early done bit %0d", tag, i), done, 1'b0);
      end else begin
        if (bus) run++; else run = 0;
        if (run == IDLE_RUN) begin
          chk({tag, " R5 done after quiet bus"}, done, 1'b1);
          chk({tag, " R5 arb_lost held"}, arb_lost, 1'b1);
          chk({tag, " R5 not busy"}, busy, 1'b0);
          fin = 1;
          break;
        end
        chk($sformatf("%s R5 waiting bit %0d", tag, i), done, 1'b0);
      end
    end
    chk({tag, " R5 R7 attempt finished"}, fin, 1'b1);
    peer_bit = 1'b1;
    @(negedge clk);
    chk({tag, " R1 done is a pulse"}, done, 1'b0);
    chk({tag, " R1 idle recessive"}, tx_bit, 1'b1);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset tx_bit", tx_bit, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset done", done, 1'b0);
    chk("R7 reset ack_seen", ack_seen, 1'b0);
    chk("R4 reset arb_lost", arb_lost, 1'b0);
    chk("R6 reset bit_err", bit_err, 1'b0);

    // Two bytes, acknowledged
    peer_dom_at(ack_index(4'd2));
    run_frame("A", 11'h123, 4'd2, 64'h0000_0000_0000_A53C, 15'h2D5A, 2);

    // Empty payload, nobody acknowledges
    peer_q.delete();
    run_frame("B", 11'h7FF, 4'd0, 64'h0, 15'h7FFF, 1);

    // Length code 12 truncates to eight bytes; request inputs churn mid-frame
    peer_dom_at(ack_index(4'd12));
    noise = 1'b1;
    run_frame("C", 11'h2AA, 4'd12, 64'h0123_4567_89AB_CDEF, 15'h1234, 3);
    noise = 1'b0;

    // Peer with lower identifier wins mid-identifier, then bus noise before idle
    peer_q.delete();
    peer_q.push_back(1'b0);
    for (int k = 10; k >= 0; k--) peer_q.push_back(bit_at(64'h0F0, k));
    peer_q.push_back(1'b0); peer_q.push_back(1'b0); peer_q.push_back(1'b0);
    peer_q.push_back(1'b1); peer_q.push_back(1'b0); peer_q.push_back(1'b1);
    peer_q.push_back(1'b1); peer_q.push_back(1'b0); peer_q.push_back(1'b0);
    run_frame("D", 11'h0F8, 4'd1, 64'h55, 15'h0001, 2);

    // Loss at the final identifier bit
    peer_q.delete();
    repeat (12) peer_q.push_back(1'b0);
    run_frame("F", 11'h001, 4'd0, 64'h0, 15'h0000, 1);

    // Retry of the losing frame succeeds
    peer_dom_at(ack_index(4'd1));
    run_frame("G", 11'h0F8, 4'd1, 64'h55, 15'h0001, 2);

    // Payload bit overwritten by a dominant level aborts with a bit error
    peer_dom_at(19);
    run_frame("E", 11'h321, 4'd1, 64'hFF, 15'h0ABC, 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule